// File: doc/BRIEF.md
# Consecutive-Window Phase Lock Qualifier

This block decides when a disciplining loop can be called locked. Once per reference period an upstream phase comparator presents a signed, limited error count together with a one-cycle strobe. The block takes the magnitude of each sample and compares it with a fixed limit. A small sample moves a down-counter one step closer to zero. A large sample sets the counter back to its full start value. The lock flag is high exactly while the counter is at zero.

Lock therefore needs an unbroken run of small samples, with one sample for each count of the start value. A single large sample cancels lock or cancels the progress made so far. Clock cycles without a strobe leave the state as it is. The limit and the length of the run are parameters.

Top module: `phase_lock_qualifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lock_o` is 0 and the counter holds its full start value, so `RUN_LEN` qualifying samples are needed before lock.
- R2: The magnitude of `err_i` (two's complement) is used, so a negative sample and a positive sample of equal size have the same effect.
- R3: A strobed sample with magnitude strictly below `LIMIT` decrements the counter. `lock_o` rises in the cycle after the `RUN_LEN`-th consecutive qualifying strobe, and not before.
- R4: A strobed sample with magnitude greater than or equal to `LIMIT` reloads the counter to `RUN_LEN`. `lock_o` is 0 in the next cycle. A sample exactly equal to `LIMIT` counts as too large.
- R5: When `err_stb_i` is 0, `err_i` is ignored: neither the counter nor `lock_o` changes, whatever the value of `err_i`.
- R6: While locked, further qualifying strobes keep `lock_o` at 1. The counter stays at zero and does not wrap.
- R7: The most negative input value, -2^(ERR_W-1), is treated as a large error and re-triggers the counter.
- R8: After a re-trigger, whether from partial progress or from lock, a full run of `RUN_LEN` qualifying strobes is needed again before lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| err_i | input | ERR_W | Signed phase error sample, two's complement |
| err_stb_i | input | 1 | One-cycle strobe marking a new sample on `err_i` |
| lock_o | output | 1 | High while the qualifying run is complete |

## Verification
The bench aims at the boundary between a sample one below the limit and a sample exactly at it. A comparator built with the wrong inequality would keep counting down on the equal sample instead of re-triggering. Negative samples, including the most negative code, check that the magnitude logic neither drops the sign nor overflows. An overflowing design would treat -2^(ERR_W-1) as small and stay locked. Large values are driven while the strobe is low, both partway through a run and while locked, to catch a counter that samples every clock. Long runs after lock expose a counter that wraps below zero, because such a design drops lock after one more decrement.

// File: rtl/plq_pkg.sv
package plq_pkg;
  // Per-cycle action taken by the run counter
  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,  // no sample this cycle
    EV_STEP   = 2'd1,  // qualifying sample, counter steps down
    EV_HOLD   = 2'd2,  // qualifying sample while already at zero
    EV_RELOAD = 2'd3   // large sample, counter re-triggered
  } run_ev_t;
endpackage

// File: rtl/plq_mag_cmp.sv
module plq_mag_cmp #(
  parameter int unsigned ERR_W = 16,
  parameter int unsigned LIMIT = 100
) (
  input  logic signed [ERR_W-1:0] err_i,
  output logic        [ERR_W-1:0] mag_o,
  output logic                    large_o
);
  localparam logic [ERR_W-1:0] NEG_MIN = {1'b1, {(ERR_W-1){1'b0}}};

  // Unsigned magnitude; the most negative code maps to 2^(ERR_W-1) without overflow
  function automatic logic [ERR_W-1:0] abs_mag(input logic signed [ERR_W-1:0] v);
    logic [ERR_W-1:0] r;
    if (v[ERR_W-1]) r = ~v + 1'b1;
    else            r = v;
    return r;
  endfunction

  function automatic logic at_or_over(input logic [ERR_W-1:0] m);
    return ({1'b0, m} >= (ERR_W+1)'(LIMIT));
  endfunction

  assign mag_o   = abs_mag(err_i);
  assign large_o = at_or_over(mag_o);

  // R7: most negative code must be judged large (LIMIT below 2^(ERR_W-1))
  always_comb begin
    if (err_i == NEG_MIN && LIMIT <= (1 << (ERR_W-1)))
      a_negmin_large_r7: assert (large_o);
  end
endmodule

// File: rtl/plq_run_cnt.sv
module plq_run_cnt
  import plq_pkg::*;
#(
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             large_i,
  output logic [CNT_W-1:0] cnt_o,
  output run_ev_t          ev_o,
  output logic             lock_o
);
  localparam logic [CNT_W-1:0] START = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!stb_i)             ev_o = EV_IDLE;
    else if (large_i)       ev_o = EV_RELOAD;
    else if (cnt_q == '0)   ev_o = EV_HOLD;
    else                    ev_o = EV_STEP;
  end

  always_comb begin
    unique case (ev_o)
      EV_RELOAD: cnt_d = START;
      EV_STEP:   cnt_d = cnt_q - 1'b1;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= START;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign lock_o = (cnt_q == '0);

  p_step_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !large_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && large_i) |=> (cnt_q == START && !lock_o));
  p_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> ($stable(cnt_q) && $stable(lock_o)));
  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && stb_i && !large_i) |=> lock_o);
  p_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= START);
endmodule

// File: rtl/phase_lock_qualifier.sv
module phase_lock_qualifier
  import plq_pkg::*;
#(
  parameter int unsigned ERR_W   = 16,
  parameter int unsigned LIMIT   = 100,
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    err_stb_i,
  output logic                    lock_o
);
  logic [ERR_W-1:0] err_mag;
  logic             err_large;
  logic [CNT_W-1:0] run_cnt;
  run_ev_t          run_ev;
  logic             lock_w;

  plq_mag_cmp #(.ERR_W(ERR_W), .LIMIT(LIMIT)) u_cmp (
    .err_i   (err_i),
    .mag_o   (err_mag),
    .large_o (err_large)
  );

  plq_run_cnt #(.RUN_LEN(RUN_LEN)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (err_stb_i),
    .large_i (err_large),
    .cnt_o   (run_cnt),
    .ev_o    (run_ev),
    .lock_o  (lock_w)
  );

  assign lock_o = lock_w;

  // R1: the cycle after reset release starts unlocked
  p_reset_unlocked_r1: assert property (@(posedge clk_i)
    !rst_ni |=> !lock_o);
  // R3: lock can only rise on a qualifying strobe
  p_lock_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(run_ev) == EV_STEP));
  // R2: a large strobed sample always leaves the block unlocked
  p_large_unlocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_stb_i && err_mag >= ERR_W'(LIMIT)) |=> !lock_o);
endmodule

// File: tb/test_phase_lock_qualifier.sv
`timescale 1ns/1ps
module test_phase_lock_qualifier;
  localparam int ERR_W = 16;
  localparam int LIMIT = 100;
  localparam int RUN   = 5;

  typedef struct { bit exp; string tag; } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic signed [ERR_W-1:0] err = '0;
  logic stb = 0;
  logic lock;

  int checks = 0, fails = 0;
  item_t q[$];
  int m_cnt = RUN;
  bit drv_done = 0;

  always #2 clk = ~clk;

  phase_lock_qualifier #(.ERR_W(ERR_W), .LIMIT(LIMIT), .RUN_LEN(RUN)) i_phase_lock_qualifier (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .err_stb_i(stb), .lock_o(lock)
  );

  // Drive one cycle at the falling edge and queue the expected lock after the next rise
  task automatic send(input int e, input bit s, input string tag);
    int m;
    item_t it;
    @(negedge clk);
    err = ERR_W'(e);
    stb = s;
    m = (e < 0) ? -e : e;
    if (s) begin
      if (m >= LIMIT) m_cnt = RUN;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
    it.exp = (m_cnt == 0);
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (lock !== it.exp) begin
          fails++;
          $display("FAIL %s: lock=%0b expected %0b", it.tag, lock, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (lock !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: lock=%0b expected 0", lock);
    end
    rst_n = 1;
    send(0, 0, "R1 after reset");
    // R1/R3: exactly RUN qualifying strobes for lock, mixed signs (R2)
    send(10, 1, "R3 step");
    send(-20, 1, "R2 negative step");
    send(99, 1, "R3 just below limit");
    send(-99, 1, "R2 negative just below");
    send(0, 1, "R3 fifth sample locks");
    // R6: stays locked, no wrap
    for (int i = 0; i < 8; i++) send(i * 7, 1, "R6 hold lock");
    // R5: large values without strobe while locked
    send(32767, 0, "R5 idle large while locked");
    send(-32768, 0, "R5 idle negmin while locked");
    // R4: equal to limit re-triggers
    send(100, 1, "R4 equal to limit");
    // R8: partial progress, idle large values, then a re-trigger
    send(5, 1, "R8 step1");
    send(500, 0, "R5 idle mid run");
    send(6, 1, "R8 step2");
    send(7, 1, "R8 step3");
    send(-100, 1, "R4 negative equal re-trigger");
    for (int i = 0; i < 4; i++) send(-1, 1, "R8 rerun not yet");
    send(1, 1, "R8 rerun locks");
    // R7: most negative code re-triggers
    send(-32768, 1, "R7 negmin re-trigger");
    for (int i = 0; i < RUN; i++) send(3, 1, "R8 run after negmin");
    send(-101, 1, "R2 negative over limit");
    send(0, 0, "R4 stays unlocked");
    drv_done = 1;
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule